// File: doc/BRIEF.md
# SD Card Single-Block Reader (SPI Mode)

This block is the host side of a single-block read from an SD or MMC card that has already been initialised into SPI mode. A one-cycle `start` request latches a 32-bit block address and an SCLK divider. The block then selects the card and shifts out a six-byte read command. It polls the card byte by byte, first for the one-byte command response and then for the data start token. After the token it shifts in a block of `BLOCK_BYTES` payload bytes followed by a two-byte checksum. Each payload byte appears for one cycle on `rd_valid`/`rd_data`. The checksum is clocked in but neither presented nor checked.

The card protocol synchronises itself, so the block needs no fixed delays. Each hunt phase is bounded instead by a programmable count of polled bytes. At the end of every transaction the block releases chip-select, clocks one idle byte and pulses `done`, with a result code on `status`. For card-reported failures, `err_code` carries the byte the card returned. `latency` holds the card access time in clock cycles, counted from the first cycle of the command up to the cycle that consumes the start token.

SPI timing is mode 0: SCLK idles low, the host samples MISO on the rising edge and changes MOSI on the falling edge. `clk_div` can be changed between transactions, for example slow during bring-up and fast for data.

Top module: `sd_block_reader`

## Requirements
- R1: After an accepted `start`, while `cs_n` is low, the first six bytes on `mosi` are 0x51, then the latched address with its most significant byte first, then 0xFF. Each byte is sent most significant bit first, and SCLK is low whenever the block is idle.
- R2: After the command, the block polls the card with 0xFF bytes. The first polled byte whose bit 7 is 0 is taken as the response, and a response of 0x00 moves on to the token hunt.
- R3: A response with bit 7 clear and a nonzero value ends the read with `status` = 1 and `err_code` = that response, and no `rd_valid` pulse occurs.
- R4: If `r1_limit` consecutive polled bytes all have bit 7 set, the read ends with `status` = 3 and `err_code` = 0.
- R5: A polled byte of 0xFE in the token hunt starts the data phase. Exactly `BLOCK_BYTES` bytes are then presented in arrival order, one `rd_valid` pulse each, and the read ends with `status` = 0. The two checksum bytes that follow are clocked in but not presented.
- R6: A polled byte in the token hunt whose bits 7:5 are all 0 ends the read with `status` = 2 and `err_code` = that byte. Any other non-0xFE byte keeps the hunt going.
- R7: If `tok_limit` polled bytes in the token hunt bring neither the start token nor an error token, the read ends with `status` = 4 and `err_code` = 0.
- R8: On a successful read, `latency` equals N × (16 × (D + 1) + 2). Here N is the number of bytes exchanged up to and including the start token, and D is the latched divider.
- R9: `cs_n` stays low from the command to the last checksum byte. Exactly one further byte (8 SCLK rising edges) is clocked with `cs_n` high. Then `done` pulses for one cycle, with `busy` already low.
- R10: In reset, and after any reset during a transfer, `cs_n` = 1, `sclk` = 0, `mosi` = 1, and `busy`, `done` and `rd_valid` are all 0.
- R11: Each SCLK high phase lasts `clk_div` + 1 clock cycles, using the value latched at `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a read; taken only when idle |
| blk_addr | input | 32 | Block address sent in the command |
| clk_div | input | DIV_W | Half-period of SCLK minus one, in clock cycles |
| r1_limit | input | TO_W | Maximum polled bytes while hunting the response |
| tok_limit | input | TO_W | Maximum polled bytes while hunting the start token |
| sclk | output | 1 | SPI clock to the card |
| cs_n | output | 1 | Active-low card select |
| mosi | output | 1 | Serial data to the card |
| miso | input | 1 | Serial data from the card |
| busy | output | 1 | A transaction is in progress |
| rd_valid | output | 1 | `rd_data` holds a payload byte this cycle |
| rd_data | output | 8 | Payload byte |
| done | output | 1 | One-cycle end-of-transaction pulse |
| status | output | 3 | Result: 0 ok, 1 response error, 2 data error token, 3 response timeout, 4 token timeout |
| err_code | output | 8 | Byte reported by the card on results 1 and 2, else 0 |
| latency | output | LAT_W | Access time in clock cycles |

## Verification
The bench builds the block with `BLOCK_BYTES` = 16 and `TO_W` = 8, and leaves `DIV_W` at 8 and `LAT_W` at 24. With the short block, every vector runs through the whole data and checksum phase in a few hundred cycles. With hunt limits of 8, both timeouts and the one-byte-inside boundary can be reached with a short stream of idle bytes. Dividers of 0, 1 and 2 across the vectors exercise the run-time rate change, and give three different byte periods for the latency formula.

// File: rtl/sdrd_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the SPI-mode block reader.
// Assumes the card is already in SPI mode and set to the block length in use.
package sdrd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_CMD, ST_R1, ST_TOK, ST_DATA, ST_TAIL
    } seq_state_t;

    typedef enum logic [2:0] {
        RES_OK          = 3'd0,
        RES_R1_ERR      = 3'd1,
        RES_TOK_ERR     = 3'd2,
        RES_R1_TIMEOUT  = 3'd3,
        RES_TOK_TIMEOUT = 3'd4
    } result_t;

    localparam int          CMD_LEN     = 6;
    localparam logic [7:0]  CMD_READ1   = 8'h51;  // start bits 01, index 17
    localparam logic [7:0]  CMD_TRAILER = 8'hFF;  // fixed checksum, end bit 1
    localparam logic [7:0]  FILL_BYTE   = 8'hFF;
    localparam logic [7:0]  START_TOKEN = 8'hFE;
endpackage

// File: rtl/sdrd_byte_xfer.sv
`timescale 1ns/1ps
// Mode-0 SPI byte engine: shifts one byte out on MOSI and one in from MISO.
// Each SCLK half-period lasts half_div+1 clocks. A byte takes 16*(half_div+1)
// clocks from acceptance of go until done. half_div must be stable while active.
module sdrd_byte_xfer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [7:0]       tx_byte,
    input  logic [DIV_W-1:0] half_div,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic             active,
    output logic             done,
    output logic [7:0]       rx_byte
);
    logic [7:0]       sh_q, rx_q;
    logic [2:0]       bit_q;
    logic [DIV_W-1:0] tick_q;
    logic             sclk_q, act_q, done_q;

    // Half-period timing, rising-edge sampling, falling-edge shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '1; rx_q <= '0; bit_q <= '0; tick_q <= '0;
            sclk_q <= 1'b0; act_q <= 1'b0; done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!act_q) begin
                if (go) begin
                    act_q  <= 1'b1;
                    sh_q   <= tx_byte;
                    bit_q  <= '0;
                    tick_q <= '0;
                end
            end else if (tick_q != half_div) begin
                tick_q <= tick_q + 1'b1;
            end else begin
                tick_q <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_q   <= {rx_q[6:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    if (bit_q == 3'd7) begin
                        act_q  <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                        sh_q  <= {sh_q[6:0], 1'b1};
                    end
                end
            end
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = act_q ? sh_q[7] : 1'b1;
    assign active  = act_q;
    assign done    = done_q;
    assign rx_byte = rx_q;
endmodule

// File: rtl/sdrd_cmd_frame.sv
`timescale 1ns/1ps
// Selects the command-frame byte for position idx (0..5): the command byte,
// four address bytes with the most significant first, then the trailer.
module sdrd_cmd_frame (
    input  logic [31:0] addr,
    input  logic [2:0]  idx,
    output logic [7:0]  frame_byte
);
    import sdrd_pkg::*;

    // Position-to-byte lookup.
    always_comb begin
        case (idx)
            3'd0:    frame_byte = CMD_READ1;
            3'd1:    frame_byte = addr[31:24];
            3'd2:    frame_byte = addr[23:16];
            3'd3:    frame_byte = addr[15:8];
            3'd4:    frame_byte = addr[7:0];
            default: frame_byte = CMD_TRAILER;
        endcase
    end
endmodule

// File: rtl/sdrd_token_class.sv
`timescale 1ns/1ps
// Classifies a received byte for the response and token hunts.
module sdrd_token_class (
    input  logic [7:0] rx,
    output logic       is_resp,
    output logic       is_clean,
    output logic       is_start,
    output logic       is_err_tok
);
    import sdrd_pkg::*;

    // Pure decode of the byte just received.
    always_comb begin
        is_resp    = ~rx[7];
        is_clean   = (rx == 8'h00);
        is_start   = (rx == START_TOKEN);
        is_err_tok = (rx[7:5] == 3'b000);
    end
endmodule

// File: rtl/sd_block_reader.sv
`timescale 1ns/1ps
// Host-side sequencer for one SPI-mode block read: command, response hunt,
// token hunt, payload plus two checksum bytes, then one deselected idle byte.
// Assumes an initialised card; the checksum is not verified.
module sd_block_reader #(
    parameter int BLOCK_BYTES = 512,
    parameter int DIV_W       = 8,
    parameter int TO_W        = 16,
    parameter int LAT_W       = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      blk_addr,
    input  logic [DIV_W-1:0] clk_div,
    input  logic [TO_W-1:0]  r1_limit,
    input  logic [TO_W-1:0]  tok_limit,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso,
    output logic             busy,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic [2:0]       status,
    output logic [7:0]       err_code,
    output logic [LAT_W-1:0] latency
);
    import sdrd_pkg::*;

    localparam int DCNT_W = $clog2(BLOCK_BYTES + 2) + 1;
    localparam int CNT_W  = (DCNT_W > TO_W) ? DCNT_W : TO_W;
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BLOCK_BYTES - 1);
    localparam logic [CNT_W-1:0] LAST_CRC  = CNT_W'(BLOCK_BYTES + 1);

    seq_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [31:0]      addr_q;
    logic [DIV_W-1:0] div_q;
    result_t          res_q;
    logic [7:0]       err_q, rdd_q;
    logic [LAT_W-1:0] lat_q;
    logic             cs_n_q, rdv_q, done_q;

    logic       x_go, x_active, x_done;
    logic [7:0] x_tx, x_rx, frame_byte;
    logic       c_resp, c_clean, c_start, c_err;
    logic       r1_last, tok_last;

    sdrd_byte_xfer #(.DIV_W(DIV_W)) u_xfer (
        .clk(clk), .rst_n(rst_n), .go(x_go), .tx_byte(x_tx), .half_div(div_q),
        .miso(miso), .sclk(sclk), .mosi(mosi), .active(x_active),
        .done(x_done), .rx_byte(x_rx)
    );

    sdrd_cmd_frame u_frame (.addr(addr_q), .idx(cnt_q[2:0]), .frame_byte(frame_byte));

    sdrd_token_class u_class (
        .rx(x_rx), .is_resp(c_resp), .is_clean(c_clean),
        .is_start(c_start), .is_err_tok(c_err)
    );

    // Launch the next byte one cycle after the previous one is consumed.
    assign x_go     = (state_q != ST_IDLE) && !x_active && !x_done;
    assign x_tx     = (state_q == ST_CMD) ? frame_byte : FILL_BYTE;
    assign r1_last  = (cnt_q == CNT_W'(r1_limit) - CNT_W'(1));
    assign tok_last = (cnt_q == CNT_W'(tok_limit) - CNT_W'(1));

    // Transaction sequencing, result capture and access-time counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE; cnt_q <= '0; addr_q <= '0; div_q <= '0;
            res_q <= RES_OK; err_q <= '0; rdd_q <= '0; lat_q <= '0;
            cs_n_q <= 1'b1; rdv_q <= 1'b0; done_q <= 1'b0;
        end else begin
            rdv_q  <= 1'b0;
            done_q <= 1'b0;
            if (state_q inside {ST_CMD, ST_R1, ST_TOK}) lat_q <= lat_q + 1'b1;
            case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_CMD;  cnt_q <= '0;
                    addr_q  <= blk_addr; div_q <= clk_div;
                    res_q   <= RES_OK;  err_q <= '0; lat_q <= '0;
                    cs_n_q  <= 1'b0;
                end
                ST_CMD: if (x_done) begin
                    if (cnt_q == CNT_W'(CMD_LEN - 1)) begin
                        state_q <= ST_R1; cnt_q <= '0;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                ST_R1: if (x_done) begin
                    if (c_resp && c_clean) begin
                        state_q <= ST_TOK; cnt_q <= '0;
                    end else if (c_resp) begin
                        res_q <= RES_R1_ERR; err_q <= x_rx;
                        state_q <= ST_TAIL; cs_n_q <= 1'b1;
                    end else if (r1_last) begin
                        res_q <= RES_R1_TIMEOUT;
                        state_q <= ST_TAIL; cs_n_q <= 1'b1;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                ST_TOK: if (x_done) begin
                    if (c_start) begin
                        state_q <= ST_DATA; cnt_q <= '0;
                    end else if (c_err) begin
                        res_q <= RES_TOK_ERR; err_q <= x_rx;
                        state_q <= ST_TAIL; cs_n_q <= 1'b1;
                    end else if (tok_last) begin
                        res_q <= RES_TOK_TIMEOUT;
                        state_q <= ST_TAIL; cs_n_q <= 1'b1;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                ST_DATA: if (x_done) begin
                    if (cnt_q <= LAST_DATA) begin
                        rdv_q <= 1'b1; rdd_q <= x_rx;
                    end
                    if (cnt_q == LAST_CRC) begin
                        state_q <= ST_TAIL; cs_n_q <= 1'b1;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                ST_TAIL: if (x_done) begin
                    state_q <= ST_IDLE; done_q <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cs_n     = cs_n_q;
    assign busy     = (state_q != ST_IDLE);
    assign rd_valid = rdv_q;
    assign rd_data  = rdd_q;
    assign done     = done_q;
    assign status   = res_q;
    assign err_code = err_q;
    assign latency  = lat_q;
endmodule

// File: rtl/sdrd_checker.sv
`timescale 1ns/1ps
// Port-level protocol checks for sd_block_reader, attached by bind.
module sdrd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sclk,
    input logic       busy,
    input logic       rd_valid,
    input logic       done,
    input logic [2:0] status,
    input logic [7:0] err_code
);
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && !sclk));

    assert_valid_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !cs_n);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !busy));

    assert_resp_err_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 3'd1) |-> (err_code != 8'h00 && !err_code[7]));

    assert_tok_err_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 3'd2) |-> (err_code[7:5] == 3'b000));
endmodule

bind sd_block_reader sdrd_checker u_sdrd_checker (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .busy(busy),
    .rd_valid(rd_valid), .done(done), .status(status), .err_code(err_code)
);

// File: tb/tb_sd_block_reader.sv
`timescale 1ns/1ps
module tb_sd_block_reader;
    localparam int BLK = 16;
    localparam int TOW = 8;
    localparam int DW  = 8;
    localparam int LW  = 24;
    localparam int NV  = 7;

    // Vector fields: pad, r1, gap, token, seed, div, r1_lim, tok_lim, exp_status, exp_err
    localparam logic [79:0] VEC [NV] = '{
        {8'd0, 8'h00, 8'd0, 8'hFE, 8'h10, 8'd0, 8'd8, 8'd8, 8'd0, 8'h00},
        {8'd3, 8'h00, 8'd5, 8'hFE, 8'h77, 8'd2, 8'd8, 8'd8, 8'd0, 8'h00},
        {8'd1, 8'h05, 8'd0, 8'hFE, 8'h00, 8'd1, 8'd8, 8'd8, 8'd1, 8'h05},
        {8'd0, 8'h00, 8'd2, 8'h09, 8'h00, 8'd0, 8'd8, 8'd8, 8'd2, 8'h09},
        {8'd8, 8'h00, 8'd0, 8'hFE, 8'h00, 8'd0, 8'd8, 8'd8, 8'd3, 8'h00},
        {8'd0, 8'h00, 8'd8, 8'hFE, 8'h00, 8'd0, 8'd8, 8'd8, 8'd4, 8'h00},
        {8'd7, 8'h00, 8'd7, 8'hFE, 8'hC3, 8'd1, 8'd8, 8'd8, 8'd0, 8'h00}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [31:0] blk_addr = '0;
    logic [DW-1:0] clk_div = '0;
    logic [TOW-1:0] r1_limit = 8'd8, tok_limit = 8'd8;
    logic sclk, cs_n, mosi, miso, busy, rd_valid, done;
    logic [7:0] rd_data, err_code;
    logic [2:0] status;
    logic [LW-1:0] latency;

    always #2.5 clk = ~clk;

    sd_block_reader #(.BLOCK_BYTES(BLK), .DIV_W(DW), .TO_W(TOW), .LAT_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_addr(blk_addr),
        .clk_div(clk_div), .r1_limit(r1_limit), .tok_limit(tok_limit),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .status(status),
        .err_code(err_code), .latency(latency)
    );

    int checks = 0, errors = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Card model state
    int m_pad = 0, m_gap = 0, m_byte = 0, m_bit = 0, tail_rises = 0;
    logic [7:0] m_r1 = 8'h00, m_tok = 8'hFE, m_seed = 8'h00, m_sr = 8'h00;
    logic [7:0] cmd_rx [6];

    function automatic logic [7:0] data_byte(logic [7:0] seed, int i);
        return 8'(int'(seed) + 3 * i);
    endfunction

    function automatic logic resp_bit(int k, int b, int pad, int gap,
                                      logic [7:0] r1, logic [7:0] tok, logic [7:0] seed);
        logic [7:0] v;
        int j, i;
        v = 8'hFF;
        if (k >= 6) begin
            j = k - 6;
            i = j - (pad + gap + 2);
            if (j == pad) v = r1;
            else if (j == pad + gap + 1) v = tok;
            else if (i >= 0 && i < BLK) v = data_byte(seed, i);
            else if (i == BLK) v = 8'hAA;
            else if (i == BLK + 1) v = 8'h55;
        end
        return v[7 - b];
    endfunction

    assign miso = cs_n ? 1'b1 : resp_bit(m_byte, m_bit, m_pad, m_gap, m_r1, m_tok, m_seed);

    // Card side: sample MOSI on rising SCLK, advance the bit/byte position.
    always @(posedge sclk) begin
        if (cs_n) tail_rises++;
        else begin
            m_sr = {m_sr[6:0], mosi};
            if (m_bit == 7) begin
                if (m_byte < 6) cmd_rx[m_byte] = m_sr;
                m_bit = 0;
                m_byte++;
            end else m_bit++;
        end
    end

    // Payload monitor and SCLK high-phase width monitor.
    int rx_cnt = 0, rx_bad = 0, hi_run = 0, last_hi = 0;
    always @(negedge clk) begin
        if (rd_valid) begin
            if (rd_data !== data_byte(m_seed, rx_cnt)) rx_bad++;
            rx_cnt++;
        end
        if (sclk) hi_run++;
        else if (hi_run != 0) begin
            last_hi = hi_run;
            hi_run = 0;
        end
    end

    function automatic string st_tag(int st, int pad);
        case (st)
            0: return (pad > 0) ? "R2" : "R5";
            1: return "R3";
            2: return "R6";
            3: return "R4";
            default: return "R7";
        endcase
    endfunction

    task automatic launch(input logic [79:0] v, input logic [31:0] a);
        m_pad = int'(v[79:72]); m_r1 = v[71:64]; m_gap = int'(v[63:56]);
        m_tok = v[55:48]; m_seed = v[47:40];
        clk_div = v[39:32]; r1_limit = v[31:24]; tok_limit = v[23:16];
        blk_addr = a;
        m_byte = 0; m_bit = 0; tail_rises = 0; rx_cnt = 0; rx_bad = 0; last_hi = 0;
        for (int k = 0; k < 6; k++) cmd_rx[k] = 8'h00;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        int w = 0;
        while (!done && w < 50000) begin
            @(negedge clk);
            w++;
        end
        ok = done;
        if (!ok) check(1'b0, "watchdog", w, 0);
    endtask

    task automatic run_vec(input int idx);
        logic [79:0] v;
        logic [31:0] a;
        bit ok;
        int st, er, d, n, expl;
        v = VEC[idx];
        a = 32'h1234_5600 + 32'(idx * 32'h0101_0111);
        st = int'(v[15:8]); er = int'(v[7:0]); d = int'(v[39:32]);
        launch(v, a);
        wait_done(ok);
        if (!ok) return;
        check(status == 3'(st), st_tag(st, m_pad), status, st);
        check(err_code == 8'(er), st_tag(st, m_pad), err_code, er);
        // R1: command frame as seen by the card
        check(cmd_rx[0] == 8'h51 && cmd_rx[1] == a[31:24] && cmd_rx[2] == a[23:16] &&
              cmd_rx[3] == a[15:8] && cmd_rx[4] == a[7:0] && cmd_rx[5] == 8'hFF,
              "R1", {cmd_rx[0], cmd_rx[1], cmd_rx[2], cmd_rx[3], cmd_rx[4], cmd_rx[5]},
              {8'h51, a, 8'hFF});
        // R9: one deselected byte before done
        check(tail_rises == 8 && cs_n && !busy, "R9", tail_rises, 8);
        // R11: SCLK high phase
        check(last_hi == d + 1, "R11", last_hi, d + 1);
        if (st == 0) begin
            check(rx_cnt == BLK, "R5", rx_cnt, BLK);
            check(rx_bad == 0, "R5", rx_bad, 0);
            n = 6 + m_pad + 1 + m_gap + 1;
            expl = n * (16 * (d + 1) + 2);
            check(int'(latency) == expl, "R8", latency, expl);
        end else begin
            check(rx_cnt == 0, st_tag(st, m_pad), rx_cnt, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(cs_n && !sclk && mosi && !busy && !done && !rd_valid, "R10",
              {cs_n, sclk, mosi, busy, done, rd_valid}, 6'b101000);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n && !sclk && mosi && !busy, "R10", {cs_n, sclk, mosi, busy}, 4'b1010);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R10: reset in the middle of a transfer
        launch(VEC[0], 32'hDEAD_BEEF);
        repeat (150) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(cs_n && !sclk && mosi && !busy && !rd_valid && !done, "R10",
              {cs_n, sclk, mosi, busy, rd_valid, done}, 6'b101000);
        rst_n = 1'b1;
        @(negedge clk);
        // Recovery after reset: a full read works again
        run_vec(1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule